// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a signed 64-bit accumulator as two 32-bit halves, an upper word and a lower word. On each accepted operation it adds a signed product to that accumulator. There are two operation kinds. The long kind multiplies two signed 32-bit operands. The word kind multiplies the signed low 16 bits of each operand. A saturation-mode input selects wrapping arithmetic or clamped arithmetic, and each kind clamps in its own way.

Software-visible state is reached through direct write ports for each half and a synchronous clear. The result of an operation is registered, and a one-cycle done pulse comes with it. Operand fetch and address stepping belong to the surrounding pipeline, not to this block.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, and one cycle after a cycle with clear_i high, hi_o and lo_o are both zero and done_o is low. Clear wins over direct writes and over an operation in the same cycle.
- R2: hi_we_i loads hi_wdata_i into the upper half, and lo_we_i loads lo_wdata_i into the lower half, one cycle later. An operation issued in the same cycle as any direct write is discarded and gives no done pulse.
- R3: An operation accepted in cycle n (op_valid_i high, no clear, no direct write) updates hi_o/lo_o and raises done_o for exactly one cycle at n+1. done_o is low in every other cycle.
- R4: Long kind (op_word_i=0) with sat_en_i=0: the full signed 64-bit product of opa_i and opb_i is added to {hi_o,lo_o}, wrapping modulo 2^64.
- R5: Long kind with sat_en_i=1 and no 64-bit overflow in the addition: the sum is clamped to the range -2^47 .. 2^47-1.
- R6: Long kind with sat_en_i=1 where the 64-bit addition overflows: the result is -2^47 if the previous accumulator was negative, else 2^47-1.
- R7: Word kind (op_word_i=1) with sat_en_i=0: opa_i[15:0] and opb_i[15:0] are sign-extended, and their 32-bit product is sign-extended and added to the full 64-bit accumulator. opa_i[31:16] and opb_i[31:16] have no effect.
- R8: Word kind with sat_en_i=1 and no 32-bit overflow: lo_o becomes lo_o plus the product, and hi_o is unchanged and takes no part in the sum.
- R9: Word kind with sat_en_i=1 and 32-bit overflow in lo_o plus product: lo_o becomes 32'h80000000 if its previous value was negative, else 32'h7FFFFFFF, and hi_o becomes exactly 1.
- R10: In a cycle with no clear, no direct write and no operation, hi_o and lo_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous clear of both halves |
| op_valid_i | input | 1 | Operation strobe |
| op_word_i | input | 1 | 1 selects the 16-bit word kind, 0 selects the 32-bit long kind |
| sat_en_i | input | 1 | Saturation mode |
| opa_i | input | 32 | First operand (word kind uses bits 15:0) |
| opb_i | input | 32 | Second operand (word kind uses bits 15:0) |
| hi_we_i | input | 1 | Direct write strobe for the upper half |
| hi_wdata_i | input | 32 | Direct write data for the upper half |
| lo_we_i | input | 1 | Direct write strobe for the lower half |
| lo_wdata_i | input | 32 | Direct write data for the lower half |
| hi_o | output | 32 | Upper accumulator half |
| lo_o | output | 32 | Lower accumulator half |
| done_o | output | 1 | One-cycle pulse when an operation result is written |

## Verification
Every update path goes through exactly one register stage, so a clear, a direct write or an accepted operation shows up at hi_o, lo_o and done_o at the first rising edge after it is driven. The bench drives inputs on the falling edge, lets one rising edge pass, and samples all three outputs on the next falling edge. It then compares them with a bench model that tracks the accumulator. Idle cycles are sampled the same way, which confirms that the state holds and that done_o stays low.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    MAC_LONG = 1'b0,
    MAC_WORD = 1'b1
  } mac_kind_e;
endpackage

// File: rtl/mac_long_path.sv
module mac_long_path #(
  parameter int HALF_W = 32,
  parameter int SAT_W  = 48
) (
  input  logic [2*HALF_W-1:0] acc_i,
  input  logic [HALF_W-1:0]   a_i,
  input  logic [HALF_W-1:0]   b_i,
  input  logic                sat_i,
  output logic [2*HALF_W-1:0] nxt_o
);
  localparam int ACC_W = 2 * HALF_W;
  localparam logic signed [ACC_W-1:0] SAT_MAX = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_MIN = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] a_x, b_x, prod, sum, acc_s;
  logic ovf;

  assign a_x   = ACC_W'($signed(a_i));
  assign b_x   = ACC_W'($signed(b_i));
  assign prod  = a_x * b_x;
  assign acc_s = $signed(acc_i);
  assign sum   = acc_s + prod;
  assign ovf   = (acc_s[ACC_W-1] == prod[ACC_W-1]) && (sum[ACC_W-1] != acc_s[ACC_W-1]);

  always_comb begin
    if (!sat_i)              nxt_o = sum;
    else if (ovf)            nxt_o = acc_s[ACC_W-1] ? SAT_MIN : SAT_MAX;
    else if (sum > SAT_MAX)  nxt_o = SAT_MAX;
    else if (sum < SAT_MIN)  nxt_o = SAT_MIN;
    else                     nxt_o = sum;
  end
endmodule

// File: rtl/mac_word_path.sv
module mac_word_path #(
  parameter int HALF_W = 32,
  parameter int WORD_W = 16
) (
  input  logic [2*HALF_W-1:0] acc_i,
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   b_i,
  input  logic                sat_i,
  output logic [2*HALF_W-1:0] nxt_o
);
  localparam int ACC_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] LO_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] LO_MIN = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] HI_OVF = HALF_W'(1);

  logic signed [HALF_W-1:0] a_x, b_x, prod, lo, lo_sum;
  logic [HALF_W-1:0] hi;
  logic lo_ovf;

  assign a_x    = HALF_W'($signed(a_i));
  assign b_x    = HALF_W'($signed(b_i));
  assign prod   = a_x * b_x;
  assign hi     = acc_i[ACC_W-1:HALF_W];
  assign lo     = $signed(acc_i[HALF_W-1:0]);
  assign lo_sum = lo + prod;
  assign lo_ovf = (lo[HALF_W-1] == prod[HALF_W-1]) && (lo_sum[HALF_W-1] != lo[HALF_W-1]);

  // saturating form: 32-bit accumulate in the low half only
  always_comb begin
    if (!sat_i)      nxt_o = acc_i + ACC_W'(prod);
    else if (lo_ovf) nxt_o = {HI_OVF, lo[HALF_W-1] ? LO_MIN : LO_MAX};
    else             nxt_o = {hi, lo_sum};
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int HALF_W = 32,
  parameter int WORD_W = 16,
  parameter int SAT_W  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              op_valid_i,
  input  logic              op_word_i,
  input  logic              sat_en_i,
  input  logic [HALF_W-1:0] opa_i,
  input  logic [HALF_W-1:0] opb_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] hi_wdata_i,
  input  logic              lo_we_i,
  input  logic [HALF_W-1:0] lo_wdata_i,
  output logic [HALF_W-1:0] hi_o,
  output logic [HALF_W-1:0] lo_o,
  output logic              done_o
);
  import mac_pkg::*;
  localparam int ACC_W = 2 * HALF_W;

  logic [HALF_W-1:0] hi_q, lo_q;
  logic              done_q;
  logic [ACC_W-1:0]  acc, long_nxt, word_nxt, op_nxt;
  logic              wr_any, op_go;
  mac_kind_e         kind;

  assign acc    = {hi_q, lo_q};
  assign kind   = mac_kind_e'(op_word_i);
  assign wr_any = hi_we_i | lo_we_i;
  assign op_go  = op_valid_i & ~clear_i & ~wr_any;

  mac_long_path #(.HALF_W(HALF_W), .SAT_W(SAT_W)) u_long (
    .acc_i(acc), .a_i(opa_i), .b_i(opb_i), .sat_i(sat_en_i), .nxt_o(long_nxt)
  );

  mac_word_path #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_word (
    .acc_i(acc), .a_i(opa_i[WORD_W-1:0]), .b_i(opb_i[WORD_W-1:0]),
    .sat_i(sat_en_i), .nxt_o(word_nxt)
  );

  assign op_nxt = (kind == MAC_WORD) ? word_nxt : long_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= op_go;
      if (clear_i) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (wr_any) begin
        if (hi_we_i) hi_q <= hi_wdata_i;
        if (lo_we_i) lo_q <= lo_wdata_i;
      end else if (op_valid_i) begin
        hi_q <= op_nxt[ACC_W-1:HALF_W];
        lo_q <= op_nxt[HALF_W-1:0];
      end
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign done_o = done_q;
endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk #(
  parameter int HALF_W = 32,
  parameter int SAT_W  = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              op_valid_i,
  input logic              op_word_i,
  input logic              sat_en_i,
  input logic              hi_we_i,
  input logic [HALF_W-1:0] hi_wdata_i,
  input logic              lo_we_i,
  input logic [HALF_W-1:0] lo_wdata_i,
  input logic [HALF_W-1:0] hi_o,
  input logic [HALF_W-1:0] lo_o,
  input logic              done_o
);
  localparam int ACC_W = 2 * HALF_W;
  localparam logic signed [ACC_W-1:0] SAT_MAX = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_MIN = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic go;
  assign go = op_valid_i && !clear_i && !hi_we_i && !lo_we_i;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hi_o == '0 && lo_o == '0 && !done_o)); // R1
  AST_HI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && !clear_i) |=> hi_o == $past(hi_wdata_i)); // R2
  AST_LO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !clear_i) |=> lo_o == $past(lo_wdata_i)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> done_o); // R3
  AST_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |=> !done_o); // R3
  AST_LONG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !op_word_i && sat_en_i) |=>
      ($signed({hi_o, lo_o}) <= SAT_MAX && $signed({hi_o, lo_o}) >= SAT_MIN)); // R5
  AST_WORD_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && op_word_i && sat_en_i) |=> (hi_o == $past(hi_o) || hi_o == HALF_W'(1))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !hi_we_i && !lo_we_i && !op_valid_i) |=> ($stable(hi_o) && $stable(lo_o))); // R10
endmodule

bind mac_sat_unit mac_sat_unit_chk #(.HALF_W(HALF_W), .SAT_W(SAT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .op_valid_i(op_valid_i),
  .op_word_i(op_word_i), .sat_en_i(sat_en_i), .hi_we_i(hi_we_i),
  .hi_wdata_i(hi_wdata_i), .lo_we_i(lo_we_i), .lo_wdata_i(lo_wdata_i),
  .hi_o(hi_o), .lo_o(lo_o), .done_o(done_o)
);

// File: tb/mac_sat_unit_tb.sv
`timescale 1ns/1ps
module mac_sat_unit_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic clear, opv, opw, sat, hwe, lwe;
  logic [31:0] opa, opb, hwd, lwd, hi, lo;
  logic done;
  int checks = 0, errors = 0;
  logic [63:0] mdl = '0;

  always #10 clk = ~clk;

  mac_sat_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .op_valid_i(opv),
    .op_word_i(opw), .sat_en_i(sat), .opa_i(opa), .opb_i(opb),
    .hi_we_i(hwe), .hi_wdata_i(hwd), .lo_we_i(lwe), .lo_wdata_i(lwd),
    .hi_o(hi), .lo_o(lo), .done_o(done)
  );

  function automatic logic [63:0] ref_mac(input logic [63:0] acc, input bit word,
      input bit sat_m, input logic [31:0] a, input logic [31:0] b, output string tag);
    longint acc_s, p, r;
    longint smax, smin;
    int pw, lo_s, s32;
    bit ovf;
    smax = (longint'(1) <<< 47) - 1;
    smin = -(longint'(1) <<< 47);
    acc_s = acc;
    if (!word) begin
      p = longint'(int'(a)) * longint'(int'(b));
      r = acc_s + p;
      ovf = ((acc_s < 0) == (p < 0)) && ((r < 0) != (acc_s < 0));
      if (!sat_m) tag = "R4";
      else if (ovf) begin tag = "R6"; r = (acc_s < 0) ? smin : smax; end
      else begin tag = "R5"; if (r > smax) r = smax; else if (r < smin) r = smin; end
      return r;
    end
    pw = int'(shortint'(a[15:0])) * int'(shortint'(b[15:0]));
    if (!sat_m) begin tag = "R7"; return acc + 64'(longint'(pw)); end
    lo_s = int'(acc[31:0]);
    s32 = lo_s + pw;
    ovf = ((lo_s < 0) == (pw < 0)) && ((s32 < 0) != (lo_s < 0));
    if (ovf) begin
      tag = "R9";
      return {32'd1, (lo_s < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF};
    end
    tag = "R8";
    return {acc[63:32], 32'(s32)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    clear = 0; opv = 0; opw = 0; sat = 0; hwe = 0; lwe = 0;
    opa = '0; opb = '0; hwd = '0; lwd = '0;
  endtask

  task automatic step_check(input string tag, input bit exp_done);
    @(negedge clk);
    chk(tag, {hi, lo}, mdl);
    chk({tag, " done"}, {63'd0, done}, {63'd0, exp_done});
    idle_inputs();
  endtask

  task automatic wr(input logic [63:0] v);
    @(negedge clk);
    hwe = 1; lwe = 1; hwd = v[63:32]; lwd = v[31:0];
    mdl = v;
    step_check("R2", 1'b0);
  endtask

  task automatic do_op(input bit word, input bit sat_m, input logic [31:0] a, input logic [31:0] b);
    string tag;
    @(negedge clk);
    opv = 1; opw = word; sat = sat_m; opa = a; opb = b;
    mdl = ref_mac(mdl, word, sat_m, a, b, tag);
    step_check(tag, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 reset", {hi, lo, 63'd0, done}, '0);
    rst_ni = 1;

    // R2: direct writes, op in same cycle discarded
    wr(64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    hwe = 1; hwd = 32'hCAFE_0001; opv = 1; opa = 5; opb = 7;
    mdl[63:32] = 32'hCAFE_0001;
    step_check("R2 op dropped", 1'b0);

    // R10: idle holds, no done (R3)
    step_check("R10", 1'b0);
    step_check("R3 idle", 1'b0);

    // R1: clear beats write and op
    @(negedge clk);
    clear = 1; hwe = 1; hwd = 32'hFFFF_FFFF; opv = 1; opa = 3; opb = 3;
    mdl = '0;
    step_check("R1 clear", 1'b0);

    // R4 wrapping long
    wr(64'h7FFF_FFFF_FFFF_FFFF);
    do_op(0, 0, 32'd1, 32'd1);
    do_op(0, 0, 32'h8000_0000, 32'h8000_0000);
    // R6 long sat with 64-bit overflow, both signs
    wr(64'h7FFF_FFFF_FFFF_FFFF);
    do_op(0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    wr(64'h8000_0000_0000_0000);
    do_op(0, 1, 32'h7FFF_FFFF, 32'h8000_0000);
    // R5 clamp at both edges and inside
    wr(64'h0000_7FFF_FFFF_FFFF);
    do_op(0, 1, 32'd1, 32'd1);
    wr(64'hFFFF_8000_0000_0000);
    do_op(0, 1, 32'd1, 32'hFFFF_FFFF);
    do_op(0, 1, 32'd2, 32'd3);
    // R7 carry into high half, upper operand bits ignored
    wr(64'h0000_0000_FFFF_FFFF);
    do_op(1, 0, 32'hABCD_0001, 32'h1234_0001);
    do_op(1, 0, 32'hFFFF_8000, 32'h0000_8000);
    // R9 word overflow both signs
    wr(64'h1234_5678_7FFF_FFFF);
    do_op(1, 1, 32'd1, 32'd1);
    wr(64'h1234_5678_8000_0000);
    do_op(1, 1, 32'd1, 32'h0000_FFFF);
    // R8 word no overflow, high half untouched
    wr(64'hDEAD_BEEF_0000_0010);
    do_op(1, 1, 32'h0000_FFFF, 32'd5);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      if ($urandom % 6 == 0) begin
        case ($urandom % 4)
          0: wr({32'h0000_7FFF, $urandom});
          1: wr({32'hFFFF_8000, $urandom});
          2: wr({$urandom, 32'h7FFF_FF00 + ($urandom % 256)});
          default: wr({$urandom, $urandom});
        endcase
      end
      a = $urandom; b = $urandom;
      if ($urandom % 3 == 0) a = {a[31], {31{~a[31]}}} ^ ($urandom % 16);
      do_op($urandom % 2, $urandom % 2, a, b);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule